// File: doc/BRIEF.md
# MDIO Management Master with Completion Event

This block lets software run clause 22 management transactions on the two-wire MDC/MDIO bus through four word-wide registers. Software first sets a clock divider and an output hold count in the speed register. Writing a frame word to the data register then shifts out a 32-bit preamble followed by that word. For a read, the block releases the data line from the turnaround onward and captures the sixteen bits the PHY returns.

Every finished transaction sets a sticky completion event. Software clears it by writing a one to it, and it can be routed to a level interrupt through a mask bit. The block also starts a transaction when the divider field moves from zero to nonzero while a nonzero frame is already held. That start raises a completion event a full frame later. So an event bit that is already set tells software nothing about a read it launched afterwards. Software has to clear the event, start its read, and then wait for a fresh event before it trusts the data register.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register address 0 is the speed register. The divider field sits at bits [6:1] and the hold field at bits [10:8], and both read back as written. The hold value is meant to be ceil(f_clk / 100 MHz) - 1 and must not exceed the divider.
- R2: A transaction drives 32 ones and then the 32-bit frame word, most significant bit first. The frame word is laid out as [31:30] start 01, [29:28] opcode (10 read, 01 write), [27:23] PHY address, [22:18] register address, [17:16] turnaround and [15:0] data.
- R3: While a frame runs, each MDC half period lasts divider+1 clocks, and MDC is low when idle. If the divider is zero, a write to the data register (address 1) stores the word but starts nothing.
- R4: After the first bit, the master changes its MDIO output exactly hold clocks after each MDC falling edge. It samples MDIO on rising edges.
- R5: A speed write that moves the divider from zero to nonzero, while the data register is nonzero and no frame runs, sends the stored frame. Its completion event comes at the end of that frame, so an event clear written right after the speed write leaves the later event in place. A speed write from one nonzero divider to another starts nothing.
- R6: A completed transaction sets the event bit (address 2, bit 0) one clock after the final MDC rising edge. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R7: The interrupt output equals the event bit ANDed with the mask bit (address 3, bit 0) on every clock.
- R8: For a read opcode, the master releases MDIO from the first turnaround bit to the end of the frame. The 16 sampled bits replace data register bits [15:0] when the event is set. Before that, the data register still holds the frame word as written.
- R9: The busy bit (address 2, bit 1) reads 1 from the start of a frame until its final bit. A data register write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |
| mdio_i | input | 1 | MDIO value seen on the bus |
| irq | output | 1 | Level interrupt, masked completion event |

## Verification
The hardest case to reach is the late event from a speed write. The divider must be zero while a nonzero frame is already stored, and an event clear has to land right behind the speed write. The stimulus gets there by writing the frame first under a zero divider and confirming that no MDC edges appear. It then writes the speed register and the event clear back to back, and it waits for the PHY stub to finish the frame before reading the event. A read is also launched with a stale frame still in the data register, and a second data write is issued while the read is busy. Together these show that the data only changes when the new event appears.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_W    = 32;
    localparam int PRE_BITS   = 32;
    localparam int TOT_BITS   = PRE_BITS + FRAME_W;
    localparam int IDX_W      = $clog2(TOT_BITS);
    localparam int POS_W      = $clog2(FRAME_W);
    localparam int REL_IDX    = PRE_BITS + 14;
    localparam int SAMPLE_IDX = PRE_BITS + 16;
    localparam int RDATA_W    = 16;

    localparam logic [1:0] ADDR_SPEED = 2'd0;
    localparam logic [1:0] ADDR_DATA  = 2'd1;
    localparam logic [1:0] ADDR_EVENT = 2'd2;
    localparam logic [1:0] ADDR_MASK  = 2'd3;

    localparam int SPEED_DIV_LSB  = 1;
    localparam int SPEED_HOLD_LSB = 8;
    localparam int EVT_DONE_BIT   = 0;
    localparam int EVT_BUSY_BIT   = 1;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef struct packed {
        logic [1:0]  st;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [1:0]  ta;
        logic [15:0] data;
    } frame_t;

    function automatic logic line_bit(frame_t f, logic [IDX_W-1:0] idx);
        logic [FRAME_W-1:0] w;
        logic [IDX_W-1:0]   pos;
        w   = f;
        pos = IDX_W'(TOT_BITS - 1) - idx;
        if (idx < IDX_W'(PRE_BITS)) return 1'b1;
        return w[pos[POS_W-1:0]];
    endfunction

    function automatic logic master_owns(frame_t f, logic [IDX_W-1:0] idx);
        return !(f.op == OP_RD && idx >= IDX_W'(REL_IDX));
    endfunction

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick = run && (cnt == div);
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shift.sv
module mdio_shift
    import mdio_pkg::*;
#(
    parameter int HOLD_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  frame_t              start_frame,
    input  logic [HOLD_W-1:0]   hold,
    input  logic                rise,
    input  logic                fall,
    input  logic                mdio_i,
    output logic                busy,
    output logic                done,
    output logic                done_rd,
    output logic [RDATA_W-1:0]  rd_data,
    output logic                mdio_o,
    output logic                mdio_oe
);
    frame_t              frame_q;
    logic [IDX_W-1:0]    idx;
    logic [HOLD_W-1:0]   hcnt;
    logic                pend;
    logic                is_rd;
    logic [IDX_W-1:0]    nidx;

    assign is_rd = (frame_q.op == OP_RD);
    assign nidx  = idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            done_rd <= 1'b0;
            rd_data <= '0;
            frame_q <= '0;
            idx     <= '0;
            hcnt    <= '0;
            pend    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    frame_q <= start_frame;
                    idx     <= '0;
                    pend    <= 1'b0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b1;
                end else if (pend) begin
                    if (hcnt <= HOLD_W'(1)) begin
                        mdio_oe <= 1'b0;
                        pend    <= 1'b0;
                    end else begin
                        hcnt <= hcnt - 1'b1;
                    end
                end
            end else if (rise) begin
                if (is_rd && idx >= IDX_W'(SAMPLE_IDX))
                    rd_data <= {rd_data[RDATA_W-2:0], mdio_i};
                if (idx == IDX_W'(TOT_BITS - 1)) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    done_rd <= is_rd;
                    if (hold == '0) begin
                        mdio_oe <= 1'b0;
                    end else begin
                        pend <= 1'b1;
                        hcnt <= hold;
                    end
                end
            end else if (fall) begin
                idx <= nidx;
                if (hold == '0) begin
                    mdio_o  <= line_bit(frame_q, nidx);
                    mdio_oe <= master_owns(frame_q, nidx);
                end else begin
                    pend <= 1'b1;
                    hcnt <= hold;
                end
            end else if (pend) begin
                if (hcnt <= HOLD_W'(1)) begin
                    mdio_o  <= line_bit(frame_q, idx);
                    mdio_oe <= master_owns(frame_q, idx);
                    pend    <= 1'b0;
                end else begin
                    hcnt <= hcnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int HOLD_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                busy,
    input  logic                done,
    input  logic                done_rd,
    input  logic [RDATA_W-1:0]  rd_data,
    output logic [DIV_W-1:0]    div,
    output logic [HOLD_W-1:0]   hold,
    output logic                start,
    output frame_t              start_frame,
    output logic                evt,
    output logic [31:0]         data_q,
    output logic                irq
);
    logic             mask;
    logic             wr_speed, wr_data, clr_evt;
    logic [DIV_W-1:0] new_div;
    logic             go_data, go_speed;

    assign wr_speed = reg_wr && reg_addr == ADDR_SPEED;
    assign wr_data  = reg_wr && reg_addr == ADDR_DATA;
    assign clr_evt  = reg_wr && reg_addr == ADDR_EVENT && reg_wdata[EVT_DONE_BIT];
    assign new_div  = reg_wdata[SPEED_DIV_LSB +: DIV_W];

    assign go_data  = wr_data && !busy && div != '0;
    assign go_speed = wr_speed && !busy && div == '0 && new_div != '0 && data_q != '0;
    assign start       = go_data || go_speed;
    assign start_frame = go_data ? frame_t'(reg_wdata) : frame_t'(data_q);
    assign irq = evt && mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            div    <= '0;
            hold   <= '0;
            data_q <= '0;
            evt    <= 1'b0;
            mask   <= 1'b0;
        end else begin
            if (wr_speed) begin
                div  <= new_div;
                hold <= reg_wdata[SPEED_HOLD_LSB +: HOLD_W];
            end
            if (done && done_rd)
                data_q[RDATA_W-1:0] <= rd_data;
            if (wr_data && !busy)
                data_q <= reg_wdata;
            if (done)
                evt <= 1'b1;
            else if (clr_evt)
                evt <= 1'b0;
            if (reg_wr && reg_addr == ADDR_MASK)
                mask <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_SPEED: begin
                reg_rdata[SPEED_DIV_LSB +: DIV_W]   = div;
                reg_rdata[SPEED_HOLD_LSB +: HOLD_W] = hold;
            end
            ADDR_DATA:  reg_rdata = data_q;
            ADDR_EVENT: begin
                reg_rdata[EVT_DONE_BIT] = evt;
                reg_rdata[EVT_BUSY_BIT] = busy;
            end
            default:    reg_rdata[0] = mask;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int HOLD_W = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        irq
);
    logic [DIV_W-1:0]   div_w;
    logic [HOLD_W-1:0]  hold_w;
    logic               start_w, busy_w, done_w, done_rd_w, evt_w;
    logic               rise_w, fall_w;
    frame_t             frame_w;
    logic [RDATA_W-1:0] rd_w;
    logic [31:0]        data_w;

    mdio_regs #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy_w), .done(done_w), .done_rd(done_rd_w), .rd_data(rd_w),
        .div(div_w), .hold(hold_w), .start(start_w), .start_frame(frame_w),
        .evt(evt_w), .data_q(data_w), .irq(irq)
    );

    mdc_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .run(busy_w), .div(div_w),
        .mdc(mdc), .rise(rise_w), .fall(fall_w)
    );

    mdio_shift #(.HOLD_W(HOLD_W)) u_shift (
        .clk(clk), .rst(rst), .start(start_w), .start_frame(frame_w), .hold(hold_w),
        .rise(rise_w), .fall(fall_w), .mdio_i(mdio_i),
        .busy(busy_w), .done(done_w), .done_rd(done_rd_w), .rd_data(rd_w),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_checker.sv
module mdio_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy_w,
    input logic        done_w,
    input logic        evt_w,
    input logic        mdc,
    input logic        rise_w,
    input logic        fall_w,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] data_w
);
    assert_mdc_parks_R3: assert property (@(posedge clk) disable iff (rst)
        !busy_w |=> !mdc);

    assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise_w, fall_w}));

    assert_event_from_done_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_w) |-> $past(done_w));

    assert_event_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        evt_w && !(reg_wr && reg_addr == 2'd2 && reg_wdata[0]) |=> evt_w);

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        busy_w && reg_wr && reg_addr == 2'd1 |=> $stable(data_w));
endmodule

bind mdio_mgmt_master mdio_checker u_chk (
    .clk(clk), .rst(rst), .busy_w(busy_w), .done_w(done_w), .evt_w(evt_w),
    .mdc(mdc), .rise_w(rise_w), .fall_w(fall_w),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .data_w(data_w)
);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, irq;
    logic        mdio_bus;
    logic        phy_oe = 1'b0, phy_o = 1'b1;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    assign mdio_bus = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_bus), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // PHY stub: samples on MDC rise, answers reads on MDC fall
    int          k = 0;
    int          tx_cnt = 0;
    logic        op_hi = 0, op_lo = 0;
    logic [63:0] cap = '0, last_cap = '0;
    logic [15:0] phy_data = 16'hA5C3;

    always @(posedge mdc) begin
        if (k == 34) op_hi = mdio_bus;
        if (k == 35) op_lo = mdio_bus;
        cap = {cap[62:0], mdio_bus};
        k++;
    end

    always @(negedge mdc) begin
        if (k >= 64) begin
            phy_oe   = 1'b0;
            last_cap = cap;
            tx_cnt++;
            k = 0;
        end else if (op_hi && !op_lo && k >= 47) begin
            phy_oe = 1'b1;
            phy_o  = (k == 47) ? 1'b0 : phy_data[63-k];
        end
    end

    // Behavioural reference model, compared on every clock
    int   cur_div = 0, cur_hold = 0;
    bit   p_clr = 0, p_mask_wr = 0, p_mask_val = 0;
    bit   evt_m = 0, mask_m = 0, set_next = 0;
    int   rises = 0, cyc = 0, last_rise = 0, since = 0;
    logic mdc_prev = 0, o_prev = 1, oe_prev = 0;

    always @(posedge clk) begin
        p_clr      = reg_wr && reg_addr == 2'd2 && reg_wdata[0];
        p_mask_wr  = reg_wr && reg_addr == 2'd3;
        p_mask_val = reg_wdata[0];
    end

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            evt_m = 0; mask_m = 0; set_next = 0; rises = 0;
        end else begin
            evt_m    = (evt_m && !p_clr) || set_next;
            set_next = 0;
            if (p_mask_wr) mask_m = p_mask_val;
            // R7/R6: interrupt follows event and mask on every clock
            check(irq == (evt_m && mask_m), "R7 irq per clock", 64'(irq), 64'(evt_m && mask_m));
            if (mdc && !mdc_prev) begin
                if (rises > 0)
                    check(cyc - last_rise == 2 * (cur_div + 1), "R3 MDC period",
                          64'(cyc - last_rise), 64'(2 * (cur_div + 1)));
                last_rise = cyc;
                rises++;
                if (rises == 64) begin
                    set_next = 1;
                    rises = 0;
                end
            end
            if (mdc_prev && !mdc) since = 0; else since++;
            if (mdio_oe && oe_prev && mdio_o !== o_prev)
                check(since == cur_hold, "R4 output change after fall", 64'(since), 64'(cur_hold));
            if (mdio_oe && phy_oe)
                check(0, "R8 bus contention", 64'(1), 64'(0));
        end
        mdc_prev = mdc; o_prev = mdio_o; oe_prev = mdio_oe;
    end

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_tx(int old);
        for (int i = 0; i < 5000 && tx_cnt == old; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] speed_word(int d, int h);
        return (32'(d) << 1) | (32'(h) << 8);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] f_wr, f_rd, f_wr2;
        int t0;
        f_wr  = {2'b01, 2'b01, 5'h05, 5'h11, 2'b10, 16'h1234};
        f_rd  = {2'b01, 2'b10, 5'h03, 5'h02, 2'b00, 16'h0000};
        f_wr2 = {2'b01, 2'b01, 5'h1F, 5'h00, 2'b10, 16'hBEEF};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        rd_reg(2'd0, v); check(v == 0, "R1 reset speed", v, 0);
        rd_reg(2'd2, v); check(v == 0, "R6 reset event", v, 0);
        check(mdc == 0 && mdio_oe == 0 && irq == 0, "R3 reset outputs",
              {mdc, mdio_oe, irq}, 0);

        // R3: zero divider stores the frame, starts nothing
        wr_reg(2'd1, f_wr);
        repeat (200) @(negedge clk);
        check(tx_cnt == 0 && k == 0, "R3 no frame with zero divider", 64'(k), 0);
        rd_reg(2'd1, v); check(v == f_wr, "R3 frame stored", v, f_wr);
        rd_reg(2'd2, v); check(v == 0, "R3 no event", v, 0);

        // R5: speed write enables clock with pending frame; clear right after
        cur_div = 4; cur_hold = 2;
        t0 = tx_cnt;
        wr_reg(2'd0, speed_word(4, 2));
        wr_reg(2'd2, 32'h1);
        rd_reg(2'd2, v); check(v == 32'h2, "R9 busy during late frame", v, 32'h2);
        wait_tx(t0);
        rd_reg(2'd2, v); check(v == 32'h1, "R5 late event survives clear", v, 32'h1);
        check(last_cap == {32'hFFFF_FFFF, f_wr}, "R2 write line bits", last_cap, {32'hFFFF_FFFF, f_wr});
        wr_reg(2'd2, 32'h0);
        rd_reg(2'd2, v); check(v == 32'h1, "R6 write zero keeps event", v, 32'h1);
        wr_reg(2'd2, 32'h1);
        rd_reg(2'd2, v); check(v == 32'h0, "R6 write one clears", v, 0);
        rd_reg(2'd0, v); check(v == speed_word(4, 2), "R1 speed readback", v, speed_word(4, 2));

        // R8/R9: read with stale data, ignored write while busy
        wr_reg(2'd3, 32'h1);
        t0 = tx_cnt;
        wr_reg(2'd1, f_rd);
        rd_reg(2'd1, v); check(v == f_rd, "R8 stale data before event", v, f_rd);
        wr_reg(2'd1, f_wr2);
        rd_reg(2'd1, v); check(v == f_rd, "R9 write while busy ignored", v, f_rd);
        check(irq == 0, "R7 no irq before completion", 64'(irq), 0);
        wait_tx(t0);
        check(tx_cnt == t0 + 1, "R9 only one frame ran", 64'(tx_cnt), 64'(t0 + 1));
        rd_reg(2'd1, v); check(v == {f_rd[31:16], phy_data}, "R8 read data captured", v, {f_rd[31:16], phy_data});
        check(irq == 1, "R7 irq with mask set", 64'(irq), 1);
        check(last_cap[63:18] == {32'hFFFF_FFFF, f_rd[31:18]}, "R2 read header bits",
              last_cap[63:18], {32'hFFFF_FFFF, f_rd[31:18]});
        check(last_cap[15:0] == phy_data, "R8 PHY data on bus", last_cap[15:0], phy_data);
        wr_reg(2'd3, 32'h0);
        check(irq == 0, "R7 mask clears irq", 64'(irq), 0);
        wr_reg(2'd2, 32'h1);

        // R5: nonzero to nonzero divider starts nothing
        cur_div = 1; cur_hold = 1;
        t0 = tx_cnt;
        wr_reg(2'd0, speed_word(1, 1));
        repeat (300) @(negedge clk);
        check(tx_cnt == t0 && k == 0, "R5 no frame on divider change", 64'(tx_cnt), 64'(t0));

        // R2/R3/R4: faster divider, write frame
        wr_reg(2'd1, f_wr2);
        wait_tx(t0);
        check(last_cap == {32'hFFFF_FFFF, f_wr2}, "R2 second write bits", last_cap, {32'hFFFF_FFFF, f_wr2});
        rd_reg(2'd2, v); check(v == 32'h1, "R6 event after write", v, 32'h1);
        check(mdio_oe == 0, "R3 master released when idle", 64'(mdio_oe), 0);

        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule